// File: doc/BRIEF.md
# Bit-Slice Integer ALU

A purely combinational integer arithmetic and logic unit assembled from a row of identical one-bit cells. Each cell can invert its A bit and its B bit, forms the AND, the OR and the full-adder sum of the two (possibly inverted) bits, and picks one of four values as its result bit. The carries ripple from cell to cell. The cell at the top also works out the signed overflow and the true sign of the difference. That sign goes back to the bottom cell to implement signed set-on-less-than.

A 4-bit control word drives every cell. Bit 3 inverts A, bit 2 inverts B and doubles as the carry into cell 0, and bits 1:0 pick the cell output. Subtraction, NOR and set-on-less-than need no extra datapath: they come from setting the inversion bits. The block also reports a zero flag, a signed overflow flag and the carry out of the top cell. Equality of two operands is read from the zero flag after a subtraction.

Top module: `slice_alu`

## Requirements
- R1: Control 0000 gives the bitwise AND of A and B, and control 0001 gives the bitwise OR; `ovf` and `cout` are 0 for both.
- R2: Control 0010 gives A + B modulo 2^WIDTH, and `cout` is the carry out of the top bit of that sum.
- R3: Control 0110 gives A - B modulo 2^WIDTH, and `cout` is the carry out of A + ~B + 1 (1 when no borrow occurs).
- R4: Control 1100 gives the bitwise NOR of A and B.
- R5: Control 0111 gives result bit 0 = 1 exactly when A < B as two's-complement numbers, including when A - B overflows; result bits WIDTH-1 to 1 are 0.
- R6: `zero` is 1 exactly when every result bit is 0, so a subtraction of equal operands raises it.
- R7: `ovf` is 1 for controls 0010 and 0110 exactly when the two's-complement result is out of range, and it is 0 for every other control.
- R8: Any control other than 0000, 0001, 0010, 0110, 0111 and 1100 gives an all-zero result with `zero` = 1, `ovf` = 0 and `cout` = 0.
- R9: For control 0111 `cout` equals the carry out of A + ~B + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| ctrl | input | 4 | {invert A, invert B / carry in, select[1:0]} |
| result | output | WIDTH | Selected result |
| zero | output | 1 | All result bits are 0 |
| ovf | output | 1 | Signed overflow of add or subtract |
| cout | output | 1 | Carry out of the top cell |

## Verification
The bench builds the unit with WIDTH set to 5. At that width every pair of operands under all sixteen control words fits in about sixteen thousand vectors. The sweep therefore covers every carry pattern, both overflow directions, and set-on-less-than with an overflowing difference. It also reaches the corner operands 0, all ones, the most positive value and the most negative value. The cell and the cell row are the same at the default width of 32, so the 5-bit sweep exercises every structural case of the ripple chain, the top cell and the feedback into cell 0.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } cell_sel_e;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

  function automatic logic code_listed(input logic [3:0] code);
    return (code == CODE_AND) || (code == CODE_OR) || (code == CODE_ADD) ||
           (code == CODE_SUB) || (code == CODE_SLT) || (code == CODE_NOR);
  endfunction

endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import slice_alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic      a_i,
  input  logic      b_i,
  input  logic      a_inv_i,
  input  logic      b_inv_i,
  input  cell_sel_e sel_i,
  input  logic      less_i,
  input  logic      carry_i,
  output logic      res_o,
  output logic      carry_o,
  output logic      set_o,
  output logic      ovf_o
);

  logic a_eff;
  logic b_eff;
  logic sum_bit;

  always_comb begin
    a_eff   = a_i ^ a_inv_i;
    b_eff   = b_i ^ b_inv_i;
    sum_bit = a_eff ^ b_eff ^ carry_i;
    carry_o = (a_eff & b_eff) | (a_eff & carry_i) | (b_eff & carry_i);
  end

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum_bit;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      always_comb begin
        ovf_o = carry_i ^ carry_o;
        set_o = sum_bit ^ ovf_o;
      end
    end else begin : g_plain
      always_comb begin
        ovf_o = 1'b0;
        set_o = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  always_comb zero_o = ~|vec_i;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf,
  output logic             cout
);

  localparam int TOP = WIDTH - 1;

  logic             a_inv;
  logic             b_inv;
  cell_sel_e        sel;
  logic [WIDTH-1:0] raw_res;
  logic             slt_bit;
  logic             top_ovf;
  logic             top_carry;
  logic             listed;
  logic             arith_code;
  logic             carry_code;

  always_comb begin
    a_inv = ctrl[3];
    b_inv = ctrl[2];
    sel   = cell_sel_e'(ctrl[1:0]);
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic cin;
      logic co;
      logic rb;
      logic st;
      logic ov;
      logic lin;

      if (i == 0) begin : g_first
        always_comb begin
          cin = b_inv;
          lin = slt_bit;
        end
      end else begin : g_rest
        always_comb begin
          cin = g_cell[i-1].co;
          lin = 1'b0;
        end
      end

      alu_bit_cell #(
        .IS_TOP (i == TOP)
      ) u_cell (
        .a_i     (opnd_a[i]),
        .b_i     (opnd_b[i]),
        .a_inv_i (a_inv),
        .b_inv_i (b_inv),
        .sel_i   (sel),
        .less_i  (lin),
        .carry_i (cin),
        .res_o   (rb),
        .carry_o (co),
        .set_o   (st),
        .ovf_o   (ov)
      );

      assign raw_res[i] = rb;
    end
  endgenerate

  assign slt_bit   = g_cell[TOP].st;
  assign top_ovf   = g_cell[TOP].ov;
  assign top_carry = g_cell[TOP].co;

  always_comb begin
    listed     = code_listed(ctrl);
    arith_code = (ctrl == CODE_ADD) || (ctrl == CODE_SUB);
    carry_code = arith_code || (ctrl == CODE_SLT);
    result     = listed ? raw_res : '0;
    ovf        = arith_code & top_ovf;
    cout       = carry_code & top_carry;
  end

  alu_zero_detect #(
    .WIDTH (WIDTH)
  ) u_zero (
    .vec_i  (result),
    .zero_o (zero)
  );

  always_comb begin
    if (ctrl == CODE_ADD) begin
      // R2
      add_sum_chk: assert (result == WIDTH'(opnd_a + opnd_b));
    end
    if (ctrl == CODE_SUB) begin
      // R3
      sub_diff_chk: assert (result == WIDTH'(opnd_a - opnd_b));
    end
    if (ctrl == CODE_SUB && opnd_a == opnd_b) begin
      // R6
      eq_zero_chk: assert (zero);
    end
    if (ctrl == CODE_SLT) begin
      // R5
      slt_bit_chk: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)));
      // R5
      slt_upper_chk: assert (result[WIDTH-1:1] == '0);
    end
    if (!ctrl[1]) begin
      // R7
      logic_no_ovf_chk: assert (!ovf && !cout);
    end
    if (!code_listed(ctrl)) begin
      // R8
      unlisted_quiet_chk: assert (zero && !ovf && !cout);
    end
  end

endmodule

// File: tb/slice_alu_tb.sv
module slice_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 5;
  localparam int SPAN       = 1 << TW;
  localparam int MASK       = SPAN - 1;
  localparam int HALF       = SPAN / 2;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] a_in;
  logic [TW-1:0] b_in;
  logic [3:0]    ctrl_in;
  logic [TW-1:0] res_out;
  logic          zero_out;
  logic          ovf_out;
  logic          cout_out;

  int  checks;
  int  failures;
  bit  finished;

  slice_alu #(
    .WIDTH (TW)
  ) u_dut (
    .opnd_a (a_in),
    .opnd_b (b_in),
    .ctrl   (ctrl_in),
    .result (res_out),
    .zero   (zero_out),
    .ovf    (ovf_out),
    .cout   (cout_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s ctrl=%b a=%0d b=%0d actual=%0d expected=%0d",
               tag, what, ctrl_in, a_in, b_in, got, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= HALF) ? v - SPAN : v;
  endfunction

  initial begin
    checks   = 0;
    failures = 0;
    finished = 0;
    rst_n    = 1'b0;
    a_in     = '0;
    b_in     = '0;
    ctrl_in  = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: idle inputs during reset give a zero result with the zero flag set
    check("R6", "reset result", int'(res_out), 0);
    check("R6", "reset zero", int'(zero_out), 1);
    check("R7", "reset ovf", int'(ovf_out), 0);
    rst_n = 1'b1;

    for (int code = 0; code < 16; code++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          int    exp_r;
          int    exp_c;
          int    exp_v;
          int    sa;
          int    sb;
          int    s;
          string rtag;
          string ctag;
          @(posedge clk);
          ctrl_in = 4'(code);
          a_in    = TW'(a);
          b_in    = TW'(b);
          sa      = to_signed(a);
          sb      = to_signed(b);
          exp_c   = 0;
          exp_v   = 0;
          ctag    = "R9";
          case (code)
            0: begin exp_r = a & b; rtag = "R1"; end                 // R1 AND
            1: begin exp_r = a | b; rtag = "R1"; end                 // R1 OR
            2: begin                                                  // R2 add
              s = a + b; exp_r = s & MASK; exp_c = s >> TW;
              exp_v = (sa + sb >= HALF || sa + sb < -HALF) ? 1 : 0;
              rtag = "R2"; ctag = "R2";
            end
            6: begin                                                  // R3 subtract
              s = a + ((~b) & MASK) + 1; exp_r = s & MASK; exp_c = s >> TW;
              exp_v = (sa - sb >= HALF || sa - sb < -HALF) ? 1 : 0;
              rtag = "R3"; ctag = "R3";
            end
            7: begin                                                  // R5 set-less, R9 carry
              s = a + ((~b) & MASK) + 1; exp_c = s >> TW;
              exp_r = (sa < sb) ? 1 : 0; rtag = "R5";
            end
            12: begin exp_r = (~(a | b)) & MASK; rtag = "R4"; end     // R4 NOR
            default: begin exp_r = 0; rtag = "R8"; ctag = "R8"; end   // R8 unlisted
          endcase
          @(negedge clk);
          check(rtag, "result", int'(res_out), exp_r);
          check("R6", "zero", int'(zero_out), (exp_r == 0) ? 1 : 0);
          check("R7", "ovf", int'(ovf_out), exp_v);
          check(ctag, "cout", int'(cout_out), exp_c);
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule